// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a physical page. It uses a file of segment registers and a hashed page table that lives in memory. A request gives the address, whether the access is a write, whether it is an instruction fetch, and whether the processor runs in user mode. The walker first reads the segment register picked by the top address nibble. A direct-store segment and a fetch from a no-execute segment end the walk at once. In every other case the walker derives a protection key and a compare word. It then reads the eight two-word entries of the primary group in sequence from a synchronous memory port.

If the primary group yields no usable match, the same scan is repeated on the secondary group. The secondary group is found from the complemented hash. When a usable match is found, the walker decodes the two-bit protection field against the key. It then updates the referenced and changed flags in the entry's second word, and writes that word back only when a flag actually changes. The result comes back as a one-cycle response. It carries a status code, the physical address and the read and write permissions that may be cached.

The table base and the segment registers are loaded from outside. The segment registers have a simple write port. The table base is a level input. One request is in flight at a time.

Top module: `hpt_walker`

## Requirements
- R1: When the selected segment register (index = EA[31:28]) has bit 31 set, the response status is DIRECT (code 4) with both permissions 0, and no memory access is made for that request.
- R2: The key is 1 when segment bit 29 is set and the request is in user mode, or when segment bit 30 is set and the request is in supervisor mode. In all other cases the key is 0.
- R3: An instruction fetch through a segment with bit 28 set returns status NOEXEC (code 3) without any memory access. A data access through the same segment is walked normally.
- R4: The primary hash is ((vsid ^ EA[27:12]) & 0x7FFFF) << 6, where vsid = segment[23:0]. The secondary hash is ~primary & 0x01FFFFC0. The group base is (tb & 0xFFFF0000) | (hash & M) | (tb & ~M & 0xFFC0), with M = ((tb & 0x1FF) << 16) | 0xFFC0. Entry i has word0 at base+8i and word1 at base+8i+4.
- R5: An entry matches when word0 bit 31 is 1, word0 bit 6 equals the pass (0 primary, 1 secondary), and word0 & 0x7FFFFFBF equals (vsid << 7) | (EA[27:12] >> 10).
- R6: The first matching entry of a group is the one used. If a later match in the same group differs from it in word1 & 0xFFFFF07B, the group counts as having no match.
- R7: Rights come from PP = word1[1:0]. Key 0 gives read always, and write unless PP = 3. Key 1 gives nothing for PP 0, read only for PP 1 or 3, and read and write for PP 2. A granted access returns status OK (code 0) and a refused one returns PROT (code 2). In both cases the physical address is {word1[31:12], EA[11:0]} and rd_ok reports the read right.
- R8: Word1 bit 8 (referenced) is set on every usable match, including a refused one. Word1 is written back once, to its own address, only when its value changes.
- R9: Word1 bit 7 (changed) is set only by a granted write. When bit 7 stays clear, wr_ok is reported as 0 whatever PP allows.
- R10: The secondary group is read only when the primary group gave no usable match. A primary PROT result is final, and a secondary result replaces the primary one.
- R11: req_ready is high only while idle. rsp_valid is a one-cycle pulse. When neither group gives a usable match, the status is MISS (code 1) with both permissions 0.
- R12: After reset, req_ready is 1 and rsp_valid, mem_req and mem_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_we | input | 1 | Segment register write strobe |
| seg_idx | input | 4 | Segment register to write |
| seg_wdata | input | 32 | Segment register write value |
| tbase | input | 32 | Page table base and size mask |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and able to accept |
| req_ea | input | 32 | Effective address |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Processor in user mode |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_status | output | 3 | 0 OK, 1 MISS, 2 PROT, 3 NOEXEC, 4 DIRECT |
| rsp_pa | output | 32 | Physical address |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
The walk is tried with an empty table, a single entry in the primary or in the secondary group, entries whose hash-pass bit is wrong, and groups holding two matches that agree or conflict. These cases separate the match rule from the group choice and from the conflict rule. Every protection code is paired with both keys and with reads, writes and fetches, so the permission decode, the write-withholding on clean pages and the flag writeback show up as separate outcomes. Random segments, table bases and partly matching groups then check the hash and group address against an independent model.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int WORD_W    = 32;
  localparam int SEG_N     = 16;
  localparam int SEG_IW    = $clog2(SEG_N);
  localparam int GRP_N     = 8;
  localparam int GRP_WORDS = 2 * GRP_N;
  localparam int WIDX_W    = $clog2(GRP_WORDS);
  localparam int ENT_W     = $clog2(GRP_N);
  localparam int PG_OFF    = 12;

  localparam logic [WORD_W-1:0] CMP_MASK   = 32'h7FFF_FFBF;
  localparam logic [WORD_W-1:0] AGREE_MASK = 32'hFFFF_F07B;

  typedef enum logic [2:0] {
    ST_OK     = 3'd0,
    ST_MISS   = 3'd1,
    ST_PROT   = 3'd2,
    ST_NOEXEC = 3'd3,
    ST_DIRECT = 3'd4
  } hpt_status_e;

  typedef enum logic [2:0] {
    W_IDLE, W_CHECK, W_SCAN, W_PASS, W_WB, W_RESP
  } walk_state_e;
endpackage

// File: rtl/hpt_segfile.sv
module hpt_segfile
  import hpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEG_IW-1:0] widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic [SEG_IW-1:0] ridx,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] regs [SEG_N];

  for (genvar g = 0; g < SEG_N; g++) begin : g_seg
    logic [WORD_W-1:0] r_q;
    logic              r_en;
    assign r_en = we && (widx == SEG_IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     r_q <= '0;
      else if (r_en)  r_q <= wdata;
    end
    assign regs[g] = r_q;
  end

  assign rdata = regs[ridx];
endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
  import hpt_pkg::*;
(
  input  logic [WORD_W-1:0] seg,
  input  logic [WORD_W-1:0] ea,
  input  logic [WORD_W-1:0] tbase,
  input  logic              user,
  input  logic              pass,
  output logic              key,
  output logic [WORD_W-1:0] cmpw,
  output logic [WORD_W-1:0] grp
);
  logic [23:0]       vsid;
  logic [15:0]       pg;
  logic [WORD_W-1:0] h_pri, h_sel, msk;
  logic              unused_bits;

  always_comb begin
    vsid  = seg[23:0];
    pg    = ea[27:12];
    key   = (seg[29] & user) | (seg[30] & ~user);
    h_pri = {7'b0, (vsid[18:0] ^ {3'b0, pg}), 6'b0};
    h_sel = pass ? (~h_pri & 32'h01FF_FFC0) : h_pri;
    msk   = {7'b0, tbase[8:0], 16'hFFC0};
    grp   = {tbase[31:16], 16'h0} | (h_sel & msk) | (tbase & ~msk & 32'h0000_FFC0);
    cmpw  = {1'b0, vsid, 1'b0, pg[15:10]};
  end

  assign unused_bits = ^{seg[31:30], seg[28:24], ea[31:28], ea[11:0]};
endmodule

// File: rtl/hpt_pte_eval.sv
module hpt_pte_eval
  import hpt_pkg::*;
(
  input  logic [WORD_W-1:0] w0,
  input  logic [WORD_W-1:0] w1,
  input  logic [WORD_W-1:0] cmpw,
  input  logic [WORD_W-1:0] keep,
  input  logic              pass,
  input  logic              key,
  output logic              hit,
  output logic              differ,
  output logic              rd_ok,
  output logic              wr_ok
);
  always_comb begin
    hit    = w0[31] && (w0[6] == pass) && ((w0 & CMP_MASK) == cmpw);
    differ = ((keep ^ w1) & AGREE_MASK) != '0;
    if (!key) begin
      rd_ok = 1'b1;
      wr_ok = (w1[1:0] != 2'd3);
    end else begin
      rd_ok = (w1[1:0] != 2'd0);
      wr_ok = (w1[1:0] == 2'd2);
    end
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seg_we,
  input  logic [3:0]  seg_idx,
  input  logic [31:0] seg_wdata,
  input  logic [31:0] tbase,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_ea,
  input  logic        req_write,
  input  logic        req_fetch,
  input  logic        req_user,
  output logic        rsp_valid,
  output logic [2:0]  rsp_status,
  output logic [31:0] rsp_pa,
  output logic        rsp_rd_ok,
  output logic        rsp_wr_ok,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  walk_state_e        state_q, state_d;
  logic [WORD_W-1:0]  ea_q, ea_d, seg_q, seg_d, hold_q, hold_d, keep_q, keep_d;
  logic [WORD_W-1:0]  pa_q, pa_d;
  logic               wr_q, wr_d, fetch_q, fetch_d, user_q, user_d, pass_q, pass_d;
  logic               rdv_q, rdv_d, found_q, found_d, conf_q, conf_d;
  logic               grant_q, grant_d, accr_q, accr_d, accw_q, accw_d;
  logic               rok_q, rok_d, wok_q, wok_d;
  logic [WIDX_W:0]    wcnt_q, wcnt_d;
  logic [WIDX_W-1:0]  ridx_q, ridx_d;
  logic [ENT_W-1:0]   good_q, good_d;
  hpt_status_e        st_q, st_d;

  logic [WORD_W-1:0]  seg_rd, cmpw, grp, new_keep;
  logic               key, ev_hit, ev_differ, ev_r, ev_w, flag_store, run_en;

  hpt_segfile u_segs (
    .clk(clk), .rst_n(rst_i), .we(seg_we), .widx(seg_idx), .wdata(seg_wdata),
    .ridx(req_ea[WORD_W-1 -: SEG_IW]), .rdata(seg_rd)
  );

  hpt_addr_gen u_addr (
    .seg(seg_q), .ea(ea_q), .tbase(tbase), .user(user_q), .pass(pass_q),
    .key(key), .cmpw(cmpw), .grp(grp)
  );

  hpt_pte_eval u_eval (
    .w0(hold_q), .w1(mem_rdata), .cmpw(cmpw), .keep(keep_q), .pass(pass_q),
    .key(key), .hit(ev_hit), .differ(ev_differ), .rd_ok(ev_r), .wr_ok(ev_w)
  );

  always_comb begin
    state_d = state_q;  ea_d = ea_q;     seg_d = seg_q;     hold_d = hold_q;
    keep_d  = keep_q;   pa_d = pa_q;     wr_d = wr_q;       fetch_d = fetch_q;
    user_d  = user_q;   pass_d = pass_q; rdv_d = 1'b0;      found_d = found_q;
    conf_d  = conf_q;   grant_d = grant_q; accr_d = accr_q; accw_d = accw_q;
    rok_d   = rok_q;    wok_d = wok_q;   wcnt_d = wcnt_q;   ridx_d = ridx_q;
    good_d  = good_q;   st_d = st_q;
    mem_req = 1'b0;     mem_we = 1'b0;   mem_addr = grp;    mem_wdata = '0;

    new_keep = keep_q | 32'h0000_0100;
    if (!keep_q[7] && wr_q && grant_q) new_keep[7] = 1'b1;
    flag_store = (new_keep != keep_q);

    case (state_q)
      W_IDLE: if (req_valid) begin
        ea_d = req_ea; wr_d = req_write; fetch_d = req_fetch; user_d = req_user;
        seg_d = seg_rd; state_d = W_CHECK;
      end
      W_CHECK: begin
        rok_d = 1'b0; wok_d = 1'b0; pa_d = '0;
        if (seg_q[31]) begin
          st_d = ST_DIRECT; state_d = W_RESP;
        end else if (fetch_q && seg_q[28]) begin
          st_d = ST_NOEXEC; state_d = W_RESP;
        end else begin
          pass_d = 1'b0; wcnt_d = '0; found_d = 1'b0; conf_d = 1'b0; state_d = W_SCAN;
        end
      end
      W_SCAN: begin
        if (wcnt_q < (WIDX_W+1)'(GRP_WORDS)) begin
          mem_req  = 1'b1;
          mem_addr = grp | {{(WORD_W-WIDX_W-2){1'b0}}, wcnt_q[WIDX_W-1:0], 2'b00};
          rdv_d    = 1'b1;
          ridx_d   = wcnt_q[WIDX_W-1:0];
          wcnt_d   = wcnt_q + 1'b1;
        end
        if (rdv_q) begin
          if (!ridx_q[0]) begin
            hold_d = mem_rdata;
          end else if (ev_hit) begin
            if (!found_q) begin
              found_d = 1'b1; keep_d = mem_rdata; good_d = ridx_q[WIDX_W-1:1];
              accr_d  = ev_r; accw_d = ev_w; grant_d = wr_q ? ev_w : ev_r;
            end else if (ev_differ) begin
              conf_d = 1'b1;
            end
          end
          if (ridx_q == WIDX_W'(GRP_WORDS-1)) state_d = W_PASS;
        end
      end
      W_PASS: begin
        if (found_q && !conf_q) begin
          pa_d    = {keep_q[WORD_W-1:PG_OFF], ea_q[PG_OFF-1:0]};
          st_d    = grant_q ? ST_OK : ST_PROT;
          rok_d   = accr_q;
          wok_d   = accw_q && new_keep[7];
          state_d = flag_store ? W_WB : W_RESP;
        end else if (!pass_q) begin
          pass_d = 1'b1; wcnt_d = '0; found_d = 1'b0; conf_d = 1'b0; state_d = W_SCAN;
        end else begin
          st_d = ST_MISS; state_d = W_RESP;
        end
      end
      W_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = grp | {{(WORD_W-ENT_W-3){1'b0}}, good_q, 3'b100};
        mem_wdata = new_keep;
        state_d   = W_RESP;
      end
      W_RESP:  state_d = W_IDLE;
      default: state_d = W_IDLE;
    endcase
  end

  assign run_en = (state_q != W_IDLE) || req_valid;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= W_IDLE; ea_q <= '0; seg_q <= '0; hold_q <= '0; keep_q <= '0;
      pa_q <= '0; wr_q <= 1'b0; fetch_q <= 1'b0; user_q <= 1'b0; pass_q <= 1'b0;
      rdv_q <= 1'b0; found_q <= 1'b0; conf_q <= 1'b0; grant_q <= 1'b0;
      accr_q <= 1'b0; accw_q <= 1'b0; rok_q <= 1'b0; wok_q <= 1'b0;
      wcnt_q <= '0; ridx_q <= '0; good_q <= '0; st_q <= ST_OK;
    end else begin
      state_q <= state_d;
      if (run_en) begin
        ea_q <= ea_d; seg_q <= seg_d; hold_q <= hold_d; keep_q <= keep_d;
        pa_q <= pa_d; wr_q <= wr_d; fetch_q <= fetch_d; user_q <= user_d;
        pass_q <= pass_d; rdv_q <= rdv_d; found_q <= found_d; conf_q <= conf_d;
        grant_q <= grant_d; accr_q <= accr_d; accw_q <= accw_d; rok_q <= rok_d;
        wok_q <= wok_d; wcnt_q <= wcnt_d; ridx_q <= ridx_d; good_q <= good_d;
        st_q <= st_d;
      end
    end
  end

  assign req_ready  = (state_q == W_IDLE);
  assign rsp_valid  = (state_q == W_RESP);
  assign rsp_status = st_q;
  assign rsp_pa     = pa_q;
  assign rsp_rd_ok  = rok_q;
  assign rsp_wr_ok  = wok_q;
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk
  import hpt_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic [2:0]  rsp_status,
  input logic        rsp_rd_ok,
  input logic        rsp_wr_ok,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata
);
  logic mem_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       mem_seen <= 1'b0;
    else if (req_valid && req_ready)  mem_seen <= 1'b0;
    else if (mem_req)                 mem_seen <= 1'b1;
  end

  assert_direct_no_mem_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_DIRECT) |-> (!mem_seen && !rsp_rd_ok && !rsp_wr_ok));

  assert_noexec_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_NOEXEC) |-> !mem_seen);

  assert_read_stride_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_addr[5:0] != 6'd0) |->
      ($past(mem_req) && mem_addr == $past(mem_addr) + 32'd4));

  assert_write_only_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && mem_addr[2:0] == 3'b100 && mem_wdata[8]));

  assert_write_needs_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wr_ok) |-> rsp_rd_ok);

  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_miss_no_perm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_MISS) |-> (!rsp_rd_ok && !rsp_wr_ok));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);
endmodule

bind hpt_walker hpt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rd_ok(rsp_rd_ok),
  .rsp_wr_ok(rsp_wr_ok), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/hpt_walker_tb.sv
`timescale 1ns/1ps
module hpt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_we = 1'b0;
  logic [3:0]  seg_idx = '0;
  logic [31:0] seg_wdata = '0;
  logic [31:0] tbase = 32'h0010_0000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_ea = '0;
  logic        req_write = 1'b0, req_fetch = 1'b0, req_user = 1'b0;
  logic        rsp_valid;
  logic [2:0]  rsp_status;
  logic [31:0] rsp_pa;
  logic        rsp_rd_ok, rsp_wr_ok;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  hpt_walker u_dut (.*);

  logic [31:0] mem [logic [31:0]];
  logic [31:0] segm [16];
  int errors = 0, checks = 0, wr_cnt = 0;
  bit done = 1'b0;

  function automatic logic [31:0] rdm(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt++;
      end else begin
        mem_rdata <= rdm(mem_addr);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_cmp(input logic [31:0] ea, input logic [31:0] sr);
    logic [31:0] v = {8'h0, sr[23:0]};
    logic [31:0] p = {16'h0, ea[27:12]};
    return (v << 7) | (p >> 10);
  endfunction

  function automatic logic [31:0] f_grp(input logic [31:0] ea, input logic [31:0] sr, input int h);
    logic [31:0] v = {8'h0, sr[23:0]};
    logic [31:0] p = {16'h0, ea[27:12]};
    logic [31:0] hs = ((v ^ p) & 32'h0007_FFFF) << 6;
    logic [31:0] m = ((tbase & 32'h1FF) << 16) | 32'hFFC0;
    if (h == 1) hs = ~hs & 32'h01FF_FFC0;
    return (tbase & 32'hFFFF_0000) | (hs & m) | (tbase & ~m & 32'h0000_FFC0);
  endfunction

  function automatic logic [31:0] mk_w0(input logic [31:0] ea, input logic [31:0] sr, input int h);
    return 32'h8000_0000 | f_cmp(ea, sr) | ((h == 1) ? 32'h40 : 32'h0);
  endfunction

  task automatic put(input logic [31:0] ea, input int h, input int slot,
                     input logic [31:0] w0, input logic [31:0] w1);
    logic [31:0] g = f_grp(ea, segm[ea[31:28]], h);
    mem[g + 32'(8*slot)]     = w0;
    mem[g + 32'(8*slot + 4)] = w1;
  endtask

  task automatic set_seg(input int idx, input logic [31:0] v);
    @(negedge clk);
    seg_we = 1'b1; seg_idx = 4'(idx); seg_wdata = v;
    @(negedge clk);
    seg_we = 1'b0;
    segm[idx] = v;
  endtask

  function automatic void ref_walk(input logic [31:0] ea, input bit wr, input bit fe, input bit us,
                                   output logic [2:0] st, output logic [31:0] pa,
                                   output bit rok, output bit wok, output int nwr,
                                   output logic [31:0] wa, output logic [31:0] wd);
    logic [31:0] sr = segm[ea[31:28]];
    logic [31:0] grp, w0, w1, keep;
    bit key, found, conf, r, w, g;
    int good;
    st = 3'd1; pa = 0; rok = 0; wok = 0; nwr = 0; wa = 0; wd = 0;
    if (sr[31]) begin st = 3'd4; return; end
    if (fe && sr[28]) begin st = 3'd3; return; end
    key = (sr[29] && us) || (sr[30] && !us);
    for (int h = 0; h < 2; h++) begin
      grp = f_grp(ea, sr, h); found = 0; conf = 0; good = 0; keep = 0;
      for (int i = 0; i < 8; i++) begin
        w0 = rdm(grp + 32'(8*i));
        w1 = rdm(grp + 32'(8*i + 4));
        if (w0[31] && (w0[6] == (h == 1)) && ((w0 & 32'h7FFF_FFBF) == f_cmp(ea, sr))) begin
          if (!found) begin found = 1; keep = w1; good = i; end
          else if (((keep ^ w1) & 32'hFFFF_F07B) != 0) conf = 1;
        end
      end
      if (found && !conf) begin
        if (!key) begin r = 1; w = (keep[1:0] != 2'd3); end
        else begin r = (keep[1:0] != 2'd0); w = (keep[1:0] == 2'd2); end
        g = wr ? w : r;
        st = g ? 3'd0 : 3'd2;
        rok = r;
        pa = {keep[31:12], ea[11:0]};
        wd = keep | 32'h100;
        if (!keep[7] && wr && g) wd[7] = 1'b1;
        wok = w && wd[7];
        wa = grp + 32'(8*good + 4);
        nwr = (wd != keep) ? 1 : 0;
        return;
      end
    end
  endfunction

  task automatic txn(input logic [31:0] ea, input bit wr, input bit fe, input bit us, input string tag);
    logic [2:0] st; logic [31:0] pa, wa, wd; bit rok, wok; int nwr, w_start, guard;
    ref_walk(ea, wr, fe, us, st, pa, rok, wok, nwr, wa, wd);
    w_start = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_write = wr; req_fetch = fe; req_user = us;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    chk(rsp_valid, {tag, " R11 response"}, 32'(rsp_valid), 32'd1);
    chk(rsp_status == st, {tag, " status"}, 32'(rsp_status), 32'(st));
    chk(rsp_rd_ok == rok, {tag, " rd_ok"}, 32'(rsp_rd_ok), 32'(rok));
    chk(rsp_wr_ok == wok, {tag, " wr_ok R9"}, 32'(rsp_wr_ok), 32'(wok));
    if (st == 3'd0 || st == 3'd2) chk(rsp_pa == pa, {tag, " pa R7"}, rsp_pa, pa);
    chk((wr_cnt - w_start) == nwr, {tag, " writes R8"}, 32'(wr_cnt - w_start), 32'(nwr));
    if (nwr != 0) chk(rdm(wa) == wd, {tag, " flags R8"}, rdm(wa), wd);
    @(negedge clk);
    chk(!rsp_valid, {tag, " R11 pulse"}, 32'(rsp_valid), 32'd0);
  endtask

  localparam logic [31:0] EA_A = 32'h1234_5678;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 16; i++) segm[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R12 ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R12 rsp", 32'(rsp_valid), 32'd0);
    chk(mem_req == 1'b0 && mem_we == 1'b0, "R12 mem", 32'(mem_req), 32'd0);

    // supervisor key 1, user key 0
    set_seg(1, 32'h4000_0123);
    txn(EA_A, 0, 0, 0, "R11 empty miss");

    put(EA_A, 0, 3, mk_w0(EA_A, segm[1], 0), 32'hABCD_E002);
    txn(EA_A, 0, 0, 0, "R4/R5/R8 primary read");
    chk(rsp_wr_ok == 1'b0, "R9 clean page withholds write", 32'(rsp_wr_ok), 32'd0);
    txn(EA_A, 1, 0, 0, "R9 write sets changed");
    txn(EA_A, 1, 0, 0, "R8 no rewrite");

    mem.delete();
    put(EA_A, 0, 0, mk_w0(EA_A, segm[1], 0), 32'h0005_5000);
    txn(EA_A, 0, 0, 0, "R7 key1 pp0");
    chk(rsp_status == 3'd2, "R7 pp0 refused", 32'(rsp_status), 32'd2);
    txn(EA_A, 0, 0, 1, "R2 user key0");

    mem.delete();
    put(EA_A, 0, 5, mk_w0(EA_A, segm[1], 0), 32'h0007_7001);
    put(EA_A, 1, 2, mk_w0(EA_A, segm[1], 1), 32'h0008_8002);
    txn(EA_A, 1, 0, 0, "R10 primary prot final");
    chk(rsp_status == 3'd2, "R10 no secondary", 32'(rsp_status), 32'd2);

    mem.delete();
    put(EA_A, 1, 7, mk_w0(EA_A, segm[1], 1), 32'h0009_9002);
    txn(EA_A, 1, 0, 0, "R10 secondary hit");

    mem.delete();
    put(EA_A, 0, 1, mk_w0(EA_A, segm[1], 0), 32'h0011_1002);
    put(EA_A, 0, 4, mk_w0(EA_A, segm[1], 0), 32'h0022_2002);
    txn(EA_A, 0, 0, 0, "R6 conflict miss");
    put(EA_A, 1, 0, mk_w0(EA_A, segm[1], 1), 32'h0033_3002);
    txn(EA_A, 0, 0, 0, "R6/R10 conflict to secondary");

    mem.delete();
    put(EA_A, 0, 2, mk_w0(EA_A, segm[1], 0), 32'h0044_4002);
    put(EA_A, 0, 6, mk_w0(EA_A, segm[1], 0), 32'h0044_4182);
    txn(EA_A, 1, 0, 0, "R6 agree first used");

    mem.delete();
    put(EA_A, 0, 4, mk_w0(EA_A, segm[1], 1), 32'h0055_5002);
    txn(EA_A, 0, 0, 0, "R5 wrong pass bit");

    mem.delete();
    put(EA_A, 0, 3, mk_w0(EA_A, segm[1], 0), 32'h0066_6183);
    txn(EA_A, 1, 0, 1, "R7 key0 pp3 write");
    txn(EA_A, 0, 0, 1, "R7 key0 pp3 read");

    set_seg(2, 32'h8000_0000);
    txn(32'h2000_0abc, 0, 0, 0, "R1 direct store");

    set_seg(3, 32'h1000_0456);
    put(32'h3456_7000, 0, 0, mk_w0(32'h3456_7000, segm[3], 0), 32'h0077_7002);
    txn(32'h3456_7000, 0, 1, 0, "R3 noexec fetch");
    txn(32'h3456_7000, 0, 0, 0, "R3 data through noexec");

    set_seg(4, 32'h2000_0789);
    put(32'h4000_1000, 0, 6, mk_w0(32'h4000_1000, segm[4], 0), 32'h0088_8000);
    txn(32'h4000_1000, 0, 0, 1, "R2 user key1 pp0");
    txn(32'h4000_1000, 0, 0, 0, "R2 super key0 pp0");

    for (int it = 0; it < 60; it++) begin
      logic [31:0] ea, sr, base1, base2;
      int s, n;
      bit fe, wr;
      mem.delete();
      tbase = {16'($urandom), 7'h0, 9'($urandom % 4), 16'h0};
      s  = 1 + ($urandom % 15);
      sr = $urandom;
      if (($urandom % 8) != 0) sr[31] = 1'b0;
      set_seg(s, sr);
      ea = {4'(s), 28'($urandom)};
      base1 = $urandom & 32'hFFFF_FE7B;
      base2 = $urandom;
      n = $urandom % 6;
      for (int k = 0; k < n; k++) begin
        int h = $urandom % 2;
        logic [31:0] w0 = (($urandom % 5) != 0) ? mk_w0(ea, sr, h) : $urandom;
        logic [31:0] w1 = (($urandom % 4) != 0) ? (base1 | ($urandom & 32'h0000_0184)) : base2;
        put(ea, h, $urandom % 8, w0, w1);
      end
      fe = (($urandom % 5) == 0);
      wr = fe ? 1'b0 : 1'($urandom);
      txn(ea, wr, fe, 1'($urandom), "R4 random walk");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule